// File: doc/BRIEF.md
# Timer Power-Mode Gate and Stop Wakeup Unit

This unit wraps a small up-counting timer and decides, on every cycle, whether the counter may advance. The decision depends on the chip's power mode (run, halt, stop), the timer enable bit and the chosen count source. The source is either the system clock or a peripheral clock, and both arrive as one-cycle enables on a single clock. The system clock is stopped in stop mode. The peripheral clock keeps running there, so a timer on that source can still count while the chip sleeps.

When the timer runs from the peripheral clock, its control and reload registers cannot be changed safely. While the timer is enabled on that source the unit refuses every write except one that clears the enable bit, and it records each refused write in a sticky error flag. A timer interrupt that fires in stop mode with the interrupt enabled does three things: it raises a recovery request to the power manager, it sets a sticky stop flag, and it sets the sticky interrupt-request flag. The request stays up until the power manager acknowledges it. An input noise filter for the timer pin runs in every power mode.

Top module: `tmr_pwr_ctrl`

## Requirements
- R1: After synchronous reset the counter reads 1, the control word is 0, the reload reads all ones, and `tmr_irq`, `stop_flag`, `irq_flag`, `wr_err`, `wake_req` and `tin_filt` are all 0.
- R2: Control word bits are [0]=enable, [1]=source (0 system, 1 peripheral), [2]=interrupt enable, [3]=filter enable. With enable=1 and source=0, a `sys_tick` advances the counter in run (`pwr_mode`=00) and halt (01) but not in stop (10, and 11 is treated as stop). On this source `per_tick` has no effect.
- R3: With enable=1 and source=1, a `per_tick` advances the counter in every power mode, stop included, and `sys_tick` has no effect.
- R4: With enable=0 the counter holds its value in every mode, whatever the ticks do.
- R5: Each counted tick steps the counter 1, 2, ... up to the reload value. The tick that finds the counter at or above the reload value sets it back to 1 and raises `tmr_irq` for exactly one cycle.
- R6: While enable=1 and source=1 (locked), a reload write is ignored, and a control write leaves bits [3:1] unchanged. Either write sets the sticky `wr_err` if it is a reload write or tries to change bits [3:1]. Writing 1 to `clr_wdata[2]` clears `wr_err`.
- R7: While locked, a control write with bit 0 = 0 clears the enable bit. When not locked, every control and reload write takes effect and leaves `wr_err` at 0.
- R8: A timer interrupt with interrupt enable = 1 sets the sticky `irq_flag` in any mode. Interrupts with interrupt enable = 0 do not set it. Writing 1 to `clr_wdata[1]` clears only that flag.
- R9: A timer interrupt in stop mode with interrupt enable = 1 sets `wake_req` and the sticky `stop_flag` in the same cycle as `tmr_irq`. Interrupts outside stop mode raise neither. Writing 1 to `clr_wdata[0]` clears `stop_flag`.
- R10: `wake_req` stays at 1 until a cycle with `wake_ack` = 1, and it reads 0 from the following cycle.
- R11: With filter enable = 1, in any power mode, `tin_filt` takes a new input level only after that level has been sampled on FILT_LEN consecutive cycles. Shorter pulses are dropped.
- R12: With filter enable = 0, `tin_filt` follows `tmr_in` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_mode | input | 2 | Power mode: 00 run, 01 halt, 10 stop, 11 treated as stop |
| sys_tick | input | 1 | System clock count enable |
| per_tick | input | 1 | Peripheral clock count enable |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word write data |
| rld_wr | input | 1 | Reload write strobe |
| rld_wdata | input | CNT_W | Reload write data |
| clr_wr | input | 1 | Flag clear strobe |
| clr_wdata | input | 3 | Write-1-to-clear: [0] stop, [1] irq, [2] write error |
| tmr_in | input | 1 | Timer input pin, already synchronised |
| wake_ack | input | 1 | Power manager acknowledge of the recovery request |
| ctl_q | output | 4 | Current control word |
| rld_q | output | CNT_W | Current reload value |
| cnt_q | output | CNT_W | Current count |
| tmr_irq | output | 1 | One-cycle timer interrupt pulse |
| tin_filt | output | 1 | Filtered timer input |
| wake_req | output | 1 | Stop-mode recovery request, held until acknowledged |
| stop_flag | output | 1 | Sticky stop-wakeup status |
| irq_flag | output | 1 | Sticky timer interrupt request |
| wr_err | output | 1 | Sticky rejected-write flag |

## Verification
The bench builds the unit with CNT_W=16 and FILT_LEN=3, and it programs reloads of 3 to 5. These values let a wrap and its interrupt occur within a few ticks in each mode. A pulse of two cycles and a hold of three cycles then fall on either side of the filter threshold. The stop-mode scenarios walk the locked state from entry, through refused writes, to release by clearing the enable bit. Together they reach the wakeup, the acknowledge handshake and the per-bit flag clears.

// File: rtl/tmr_pwr_pkg.sv
// Shared types for the timer power-mode unit.
// Assumes: the power mode encoding is fixed by the power manager.
package tmr_pwr_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_HALT = 2'b01,
        PM_STOP = 2'b10,
        PM_RSVD = 2'b11
    } pmode_t;

    typedef struct packed {
        logic fen;   // [3] noise filter enable
        logic ien;   // [2] interrupt enable
        logic csel;  // [1] 0 system clock, 1 peripheral clock
        logic en;    // [0] timer enable
    } tctl_t;
endpackage

// File: rtl/tmr_regs.sv
// Control and reload registers with write protection.
// Writes are refused while the timer is enabled on the peripheral clock,
// except a write that clears the enable bit; refusals set a sticky flag.
// Assumes: one write strobe per register, data valid with the strobe.
module tmr_regs
    import tmr_pwr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [3:0]       ctl_wdata,
    input  logic             rld_wr,
    input  logic [CNT_W-1:0] rld_wdata,
    input  logic             err_clr,
    output tctl_t            ctl,
    output logic [CNT_W-1:0] rld,
    output logic             wr_err
);
    localparam logic [CNT_W-1:0] RLD_INIT = {CNT_W{1'b1}};

    tctl_t wd;
    logic  locked;
    logic  field_diff;
    logic  refuse;

    assign wd         = tctl_t'(ctl_wdata);
    assign locked     = ctl.en & ctl.csel;
    assign field_diff = {wd.fen, wd.ien, wd.csel} != {ctl.fen, ctl.ien, ctl.csel};
    assign refuse     = locked & (rld_wr | (ctl_wr & field_diff));

    // Register update: full write when unlocked, enable-clear only when locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
            rld <= RLD_INIT;
        end else begin
            if (ctl_wr) begin
                if (!locked) ctl    <= wd;
                else         ctl.en <= ctl.en & wd.en;
            end
            if (rld_wr && !locked) rld <= rld_wdata;
        end
    end

    // Sticky rejected-write flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= refuse | (wr_err & ~err_clr);
    end

    assert_lock_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && rld_wr) |=> $stable(rld));
    assert_lock_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && ctl_wr) |=> ({ctl.fen, ctl.ien, ctl.csel} == $past({ctl.fen, ctl.ien, ctl.csel})));
endmodule

// File: rtl/tmr_core.sv
// Timer core: selects the count enable from power mode and clock source,
// counts 1..reload and reloads to 1 with a one-cycle interrupt pulse.
// Assumes: both clocks are delivered as enables on clk.
module tmr_core
    import tmr_pwr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pmode_t           mode,
    input  logic             sys_tick,
    input  logic             per_tick,
    input  logic             en,
    input  logic             csel,
    input  logic [CNT_W-1:0] rld,
    output logic [CNT_W-1:0] cnt,
    output logic             hit,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic sys_ok;
    logic tick;

    assign sys_ok = (mode == PM_RUN) || (mode == PM_HALT);
    assign tick   = en & (csel ? per_tick : (sys_tick & sys_ok));
    assign hit    = tick & (cnt >= rld);

    // Counter with reload to 1 on reaching the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= ONE;
        else if (hit)  cnt <= ONE;
        else if (tick) cnt <= cnt + ONE;
    end

    // One-cycle interrupt pulse registered with the reload.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= hit;
    end

    assert_irq_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == ONE));
    assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == PM_STOP || mode == PM_RSVD) && !csel) |=> $stable(cnt));
    assert_en_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));
endmodule

// File: rtl/tmr_wake.sv
// Interrupt-request and stop-status flags plus the stop-mode recovery request.
// Assumes: the power manager acknowledges with a one-cycle pulse.
module tmr_wake
    import tmr_pwr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  pmode_t mode,
    input  logic   hit,
    input  logic   ien,
    input  logic   wake_ack,
    input  logic   stop_clr,
    input  logic   irq_clr,
    output logic   stop_flag,
    output logic   irq_flag,
    output logic   wake_req
);
    logic in_stop;
    logic irq_set;
    logic stop_set;

    assign in_stop  = (mode == PM_STOP) || (mode == PM_RSVD);
    assign irq_set  = hit & ien;
    assign stop_set = irq_set & in_stop;

    // Sticky flags, set wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_flag <= 1'b0;
            irq_flag  <= 1'b0;
        end else begin
            stop_flag <= stop_set | (stop_flag & ~stop_clr);
            irq_flag  <= irq_set  | (irq_flag  & ~irq_clr);
        end
    end

    // Recovery request level, held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= stop_set | (wake_req & ~wake_ack);
    end

    assert_wake_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !wake_ack) |=> wake_req);
    assert_wake_only_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_stop && !wake_req) |=> !wake_req);
    assert_wake_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> (stop_flag && irq_flag));
endmodule

// File: rtl/tmr_filt.sv
// Input noise filter: a new level passes after FILT_LEN consecutive samples.
// Runs on clk in every power mode; bypassed (one-cycle delay) when disabled.
// Assumes: tmr_in is already synchronised to clk.
module tmr_filt #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fen,
    input  logic tin,
    output logic tout
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [CW-1:0] run;

    // Count consecutive differing samples and accept the level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tout <= 1'b0;
            run  <= '0;
        end else if (!fen) begin
            tout <= tin;
            run  <= '0;
        end else if (tin == tout) begin
            run  <= '0;
        end else if (run == LAST) begin
            tout <= tin;
            run  <= '0;
        end else begin
            run  <= run + 1'b1;
        end
    end

    assert_filt_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fen && tin == tout) |=> $stable(tout));
endmodule

// File: rtl/tmr_pwr_ctrl.sv
// Top of the timer power-mode unit: registers, gated core, wakeup flags and
// input filter. Assumes a single clock with system and peripheral ticks as
// enables and the power mode driven by the power manager.
module tmr_pwr_ctrl
    import tmr_pwr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int FILT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pwr_mode,
    input  logic             sys_tick,
    input  logic             per_tick,
    input  logic             ctl_wr,
    input  logic [3:0]       ctl_wdata,
    input  logic             rld_wr,
    input  logic [CNT_W-1:0] rld_wdata,
    input  logic             clr_wr,
    input  logic [2:0]       clr_wdata,
    input  logic             tmr_in,
    input  logic             wake_ack,
    output logic [3:0]       ctl_q,
    output logic [CNT_W-1:0] rld_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tmr_irq,
    output logic             tin_filt,
    output logic             wake_req,
    output logic             stop_flag,
    output logic             irq_flag,
    output logic             wr_err
);
    pmode_t mode;
    tctl_t  ctl;
    logic   hit;

    assign mode  = pmode_t'(pwr_mode);
    assign ctl_q = ctl;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rld_wr(rld_wr), .rld_wdata(rld_wdata),
        .err_clr(clr_wr & clr_wdata[2]),
        .ctl(ctl), .rld(rld_q), .wr_err(wr_err)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .sys_tick(sys_tick), .per_tick(per_tick),
        .en(ctl.en), .csel(ctl.csel), .rld(rld_q),
        .cnt(cnt_q), .hit(hit), .irq(tmr_irq)
    );

    tmr_wake u_wake (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .hit(hit), .ien(ctl.ien), .wake_ack(wake_ack),
        .stop_clr(clr_wr & clr_wdata[0]), .irq_clr(clr_wr & clr_wdata[1]),
        .stop_flag(stop_flag), .irq_flag(irq_flag), .wake_req(wake_req)
    );

    tmr_filt #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .fen(ctl.fen),
        .tin(tmr_in), .tout(tin_filt)
    );
endmodule

// File: tb/sim_tmr_pwr_ctrl.sv
// Directed bench for tmr_pwr_ctrl: one task per scenario, inputs driven and
// outputs sampled on the falling edge.
module sim_tmr_pwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int FLEN       = 3;
    localparam int WDOG       = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       pwr_mode = 2'b00;
    logic             sys_tick = 1'b0, per_tick = 1'b0;
    logic             ctl_wr = 1'b0, rld_wr = 1'b0, clr_wr = 1'b0;
    logic [3:0]       ctl_wdata = '0;
    logic [CNT_W-1:0] rld_wdata = '0;
    logic [2:0]       clr_wdata = '0;
    logic             tmr_in = 1'b0, wake_ack = 1'b0;
    logic [3:0]       ctl_q;
    logic [CNT_W-1:0] rld_q, cnt_q;
    logic             tmr_irq, tin_filt, wake_req, stop_flag, irq_flag, wr_err;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 1;
    int exp_rld = 32'hFFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_pwr_ctrl #(.CNT_W(CNT_W), .FILT_LEN(FLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode),
        .sys_tick(sys_tick), .per_tick(per_tick),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rld_wr(rld_wr), .rld_wdata(rld_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .tmr_in(tmr_in), .wake_ack(wake_ack),
        .ctl_q(ctl_q), .rld_q(rld_q), .cnt_q(cnt_q), .tmr_irq(tmr_irq),
        .tin_filt(tin_filt), .wake_req(wake_req), .stop_flag(stop_flag),
        .irq_flag(irq_flag), .wr_err(wr_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [3:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_rld(input int v);
        rld_wr = 1'b1; rld_wdata = CNT_W'(v);
        @(negedge clk); rld_wr = 1'b0;
    endtask

    task automatic wr_clr(input logic [2:0] v);
        clr_wr = 1'b1; clr_wdata = v;
        @(negedge clk); clr_wr = 1'b0;
    endtask

    // One tick cycle; 'counts' says whether the requirements make it count.
    task automatic tick(input logic s, input logic p, input logic counts);
        sys_tick = s; per_tick = p;
        @(negedge clk); sys_tick = 1'b0; per_tick = 1'b0;
        if (counts) exp_cnt = (exp_cnt >= exp_rld) ? 1 : exp_cnt + 1;
    endtask

    task automatic t_reset();
        check("R1 cnt", int'(cnt_q), 1);
        check("R1 ctl", int'(ctl_q), 0);
        check("R1 rld", int'(rld_q), 32'hFFFF);
        check("R1 flags", int'({tmr_irq, stop_flag, irq_flag, wr_err, wake_req, tin_filt}), 0);
    endtask

    task automatic t_run_halt_stop();
        wr_rld(3); exp_rld = 3;
        wr_ctl(4'b0101);
        pwr_mode = 2'b00;
        tick(1, 0, 1); tick(1, 0, 1);
        check("R2 run count", int'(cnt_q), exp_cnt);
        tick(1, 0, 1);
        check("R5 wrap to 1", int'(cnt_q), 1);
        check("R5 irq pulse", int'(tmr_irq), 1);
        check("R8 irq flag set", int'(irq_flag), 1);
        check("R9 no wake in run", int'({wake_req, stop_flag}), 0);
        idle(1);
        check("R5 pulse one cycle", int'(tmr_irq), 0);
        tick(0, 1, 0);
        check("R2 per_tick ignored", int'(cnt_q), exp_cnt);
        pwr_mode = 2'b01;
        tick(1, 0, 1);
        check("R2 halt count", int'(cnt_q), exp_cnt);
        pwr_mode = 2'b10;
        tick(1, 0, 0); tick(1, 0, 0);
        check("R2 stop holds", int'(cnt_q), exp_cnt);
        pwr_mode = 2'b11;
        tick(1, 0, 0);
        check("R2 mode 11 holds", int'(cnt_q), exp_cnt);
        idle(3);
        check("R8 irq flag sticky", int'(irq_flag), 1);
        wr_clr(3'b010);
        check("R8 irq flag cleared", int'(irq_flag), 0);
    endtask

    task automatic t_disabled();
        wr_ctl(4'b0000);
        pwr_mode = 2'b00;
        tick(1, 1, 0); tick(1, 1, 0);
        check("R4 run disabled", int'(cnt_q), exp_cnt);
        pwr_mode = 2'b10;
        tick(1, 1, 0);
        check("R4 stop disabled", int'(cnt_q), exp_cnt);
    endtask

    task automatic t_stop_wake();
        pwr_mode = 2'b00;
        wr_ctl(4'b0111);
        pwr_mode = 2'b10;
        tick(0, 1, 1);
        check("R3 stop per count", int'(cnt_q), exp_cnt);
        tick(1, 0, 0);
        check("R3 sys ignored", int'(cnt_q), exp_cnt);
        for (int i = 0; i < 4 && exp_cnt != exp_rld; i++) tick(0, 1, 1);
        tick(0, 1, 1);
        check("R5 stop wrap", int'(cnt_q), 1);
        check("R9 wake_req", int'(wake_req), 1);
        check("R9 stop_flag", int'(stop_flag), 1);
        check("R8 irq flag in stop", int'(irq_flag), 1);
        idle(3);
        check("R10 held", int'(wake_req), 1);
        wake_ack = 1'b1; @(negedge clk); wake_ack = 1'b0;
        check("R10 cleared after ack", int'(wake_req), 0);
        pwr_mode = 2'b00;
        wr_clr(3'b001);
        check("R9 stop flag cleared", int'(stop_flag), 0);
        check("R8 irq flag kept", int'(irq_flag), 1);
        wr_clr(3'b010);
    endtask

    task automatic t_lock();
        wr_rld(7);
        check("R6 reload refused", int'(rld_q), exp_rld);
        check("R6 err set", int'(wr_err), 1);
        wr_clr(3'b100);
        check("R6 err cleared", int'(wr_err), 0);
        wr_ctl(4'b1111);
        check("R6 fields kept", int'(ctl_q), 4'b0111);
        check("R6 err on ctl", int'(wr_err), 1);
        wr_clr(3'b100);
        wr_ctl(4'b0110);
        check("R7 enable cleared", int'(ctl_q), 4'b0110);
        check("R7 no err on disable", int'(wr_err), 0);
        wr_rld(5); exp_rld = 5;
        check("R7 unlocked reload", int'(rld_q), 5);
        wr_ctl(4'b1001);
        check("R7 unlocked ctl", int'(ctl_q), 4'b1001);
        wr_rld(4); exp_rld = 4;
        check("R7 main clock reload", int'(rld_q), 4);
        check("R7 no err unlocked", int'(wr_err), 0);
    endtask

    task automatic t_no_ien();
        wr_ctl(4'b0011);
        pwr_mode = 2'b10;
        for (int i = 0; i < 5 && exp_cnt != exp_rld; i++) tick(0, 1, 1);
        tick(0, 1, 1);
        check("R5 wrap no ien", int'({cnt_q, tmr_irq}), {16'd1, 1'b1});
        check("R8 no flag without ien", int'(irq_flag), 0);
        check("R9 no wake without ien", int'({wake_req, stop_flag}), 0);
        wr_ctl(4'b0010);
    endtask

    task automatic t_filter();
        wr_ctl(4'b1000);
        pwr_mode = 2'b10;
        tmr_in = 1'b1; idle(FLEN - 1); tmr_in = 1'b0; idle(FLEN);
        check("R11 short pulse dropped", int'(tin_filt), 0);
        tmr_in = 1'b1; idle(FLEN - 1);
        check("R11 not yet", int'(tin_filt), 0);
        idle(1);
        check("R11 accepted", int'(tin_filt), 1);
        pwr_mode = 2'b01;
        tmr_in = 1'b0; idle(FLEN);
        check("R11 halt falling", int'(tin_filt), 0);
        wr_ctl(4'b0000);
        tmr_in = 1'b1; idle(1);
        check("R12 bypass follows", int'(tin_filt), 1);
        tmr_in = 1'b0; idle(1);
        check("R12 bypass low", int'(tin_filt), 0);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WDOG, 0);
        summary();
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_run_halt_stop();
        t_disabled();
        t_stop_wake();
        t_lock();
        t_no_ien();
        t_filter();
        summary();
    end
endmodule